// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial characters from a single input line. It uses a bit clock oversampled sixteen times. A start bit is confirmed at its midpoint. The data bits, the optional parity bit and one or two stop bits are then each sampled at their own midpoints, and the data bits are gathered into a shift register. When the final stop bit has been sampled, the character moves into a buffer the host can read. At that moment the buffer-full status is set and the receive interrupt request pulses for one cycle.

The frame format is set by the configuration inputs: 7, 8 or 9 data bits, no, even or odd parity, and one or two stop bits. The same settings apply to the matching transmitter. The host empties the buffer by pulsing a read strobe. Three sticky error flags report an overrun, a framing fault and a parity fault, and a fourth flag shows that any of them is present. Clearing the receive enable clears all the error flags.

Top module: `serial_rx_core`

## Requirements
- R1: While reset is asserted and after it is released, rx_data is 0, and rx_full, rx_irq and all four error flags are 0.
- R2: One bit lasts 16×(div_n+1) clock cycles. The line passes through a two-flop synchronizer. If the start edge is applied on rxd just after clock edge 0, the character is transferred (rx_irq high) just after edge 3+(8+16·B)·(div_n+1), where B is the number of bits after the start bit.
- R3: A start is accepted only if the line is still low at the 8th oversample tick. A shorter low pulse is discarded: no transfer, no flag, and the next proper frame is received correctly.
- R4: Data bits arrive LSB first and are each sampled at mid-bit. char_len selects the length (0 = 7 bits, 1 = 8 bits, 2 = 9 bits, 3 = 8 bits). Buffer bits above the selected length read as 0.
- R5: The transfer happens on the midpoint sample of the final stop bit. It loads rx_data, sets rx_full, and pulses rx_irq high for exactly one cycle.
- R6: A one-cycle pulse on rd_strobe clears rx_full on the next edge. If a transfer falls on the same edge, the transfer wins.
- R7: If rx_full is still 1 when the bit just before the final stop bit of the next frame is sampled, err_overrun is set. That frame is then not transferred: rx_data keeps the old character and rx_irq does not pulse.
- R8: err_frame is set when any configured stop bit is low at its midpoint sample.
- R9: par_mode selects the parity (0 or 3 = none, 1 = even, 2 = odd). err_parity is set when the number of ones across the data and parity bits is odd in even mode or even in odd mode.
- R10: err_sum is 1 exactly when at least one of err_overrun, err_frame or err_parity is 1.
- R11: The error flags stay set until rx_en is 0 at a clock edge, which clears all four.
- R12: While rx_en is 0 the receiver stays idle and ignores the line. A frame sent while it is disabled produces no transfer, and rx_full and rx_data keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; 0 aborts reception and clears the error flags |
| div_n | input | 8 | Bit-rate divisor n; one bit lasts 16×(n+1) cycles |
| char_len | input | 2 | Character length select |
| par_mode | input | 2 | Parity select |
| two_stop | input | 1 | 1 = two stop bits expected |
| rxd | input | 1 | Serial input line, idle high |
| rd_strobe | input | 1 | Host read of the receive buffer |
| rx_data | output | 9 | Receive buffer |
| rx_full | output | 1 | Buffer holds an unread character |
| rx_irq | output | 1 | One-cycle receive interrupt request |
| err_overrun | output | 1 | Sticky overrun flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_parity | output | 1 | Sticky parity error flag |
| err_sum | output | 1 | Any error flag set |

## Verification
The bench sends a low glitch shorter than half a bit. A receiver that does not confirm the start bit would assemble a ghost character and raise rx_irq. It sends two frames without reading the buffer in between. A design that judged overrun at the wrong bit, or still transferred the second frame, would overwrite the first character or pulse the interrupt. It corrupts the parity bit of one frame and the second stop bit of another. A receiver that ignored the second stop bit, or inverted the odd/even sense, would leave the flags clear. A design that dropped one synchronizer stage or mis-placed the midpoint would move the transfer cycle, and the cycle-by-cycle model comparison catches that.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    LEN_7 = 2'd0,
    LEN_8 = 2'd1,
    LEN_9 = 2'd2
  } char_len_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } par_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2
  } rx_state_e;

  function automatic logic [3:0] data_len(input logic [1:0] sel);
    case (sel)
      LEN_7:   data_len = 4'd7;
      LEN_9:   data_len = 4'd9;
      default: data_len = 4'd8;
    endcase
  endfunction

  function automatic logic parity_on(input logic [1:0] sel);
    parity_on = (sel == PAR_EVEN) || (sel == PAR_ODD);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
  parameter int DIV_W   = 8,
  parameter int OS_RATE = 16,
  localparam int OS_W   = $clog2(OS_RATE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             os_clr,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick,
  output logic [OS_W-1:0]  os
);
  logic [DIV_W-1:0] pcnt, pcnt_d;
  logic [OS_W-1:0]  os_d;

  always_comb begin
    tick   = run && (pcnt == div_n);
    pcnt_d = pcnt;
    os_d   = os;
    if (!run) begin
      pcnt_d = '0;
      os_d   = '0;
    end else if (tick) begin
      pcnt_d = '0;
      os_d   = os_clr ? '0 : os + 1'b1;
    end else begin
      pcnt_d = pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      os   <= '0;
    end else begin
      pcnt <= pcnt_d;
      os   <= os_d;
    end
  end

  // R2: with a divisor above zero, oversample ticks never come on adjacent cycles
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_n != '0 && $stable(div_n)) |=> !tick);
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 9,
  parameter int IDX_W   = 4,
  localparam int OS_W   = $clog2(OS_RATE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              line,
  input  logic              tick,
  input  logic [OS_W-1:0]   os,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              two_stop,
  input  logic              buf_full,
  output logic              run,
  output logic              os_clr,
  output logic [DATA_W-1:0] shreg,
  output logic              xfer,
  output logic              ovr_hit,
  output logic              fe_hit,
  output logic              pe_hit
);
  localparam logic [OS_W-1:0] OS_MID  = OS_W'(OS_RATE/2 - 1);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);

  rx_state_e         state, state_d;
  logic [IDX_W-1:0]  idx, idx_d;
  logic [DATA_W-1:0] shreg_d;
  logic              ovr_seen, ovr_seen_d;

  logic [IDX_W-1:0]  n_data, n_tot;
  logic              par_en, mid_start, mid_bit;
  logic              in_data, in_par, in_stop, last, pre_last, ones_odd;

  always_comb begin
    n_data    = IDX_W'(data_len(char_len));
    par_en    = parity_on(par_mode);
    n_tot     = n_data + IDX_W'(par_en) + IDX_W'(1) + IDX_W'(two_stop);
    mid_start = rx_en && (state == ST_START) && tick && (os == OS_MID);
    mid_bit   = rx_en && (state == ST_BITS) && tick && (os == OS_LAST);
    in_data   = idx < n_data;
    in_par    = par_en && (idx == n_data);
    in_stop   = !in_data && !in_par;
    last      = idx == n_tot - IDX_W'(1);
    pre_last  = idx == n_tot - IDX_W'(2);
    ones_odd  = (^shreg) ^ line;
    pe_hit    = mid_bit && in_par && ((par_mode == PAR_EVEN) ? ones_odd : !ones_odd);
    fe_hit    = mid_bit && in_stop && !line;
    ovr_hit   = mid_bit && pre_last && buf_full;
    xfer      = mid_bit && last && !ovr_seen;
    run       = state != ST_IDLE;
    os_clr    = mid_start;
  end

  always_comb begin
    state_d    = state;
    idx_d      = idx;
    shreg_d    = shreg;
    ovr_seen_d = ovr_seen;
    if (!rx_en) begin
      state_d = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!line) begin
            state_d    = ST_START;
            idx_d      = '0;
            shreg_d    = '0;
            ovr_seen_d = 1'b0;
          end
        end
        ST_START: begin
          if (mid_start) state_d = line ? ST_IDLE : ST_BITS;
        end
        ST_BITS: begin
          if (mid_bit) begin
            if (in_data) shreg_d[idx] = line;
            if (ovr_hit) ovr_seen_d = 1'b1;
            idx_d = idx + 1'b1;
            if (last) state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      shreg    <= '0;
      ovr_seen <= 1'b0;
    end else begin
      state    <= state_d;
      idx      <= idx_d;
      shreg    <= shreg_d;
      ovr_seen <= ovr_seen_d;
    end
  end

  // R12: a disabled receiver is idle on the following cycle
  a_r12_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state == ST_IDLE));
  // R3: a start found high again at mid-bit is dropped
  a_r3_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && state == ST_START && tick && os == OS_MID && line) |=> (state == ST_IDLE));
  // R4: short characters never carry stray upper bits into the buffer
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && char_len == LEN_7) |-> (shreg[DATA_W-1:DATA_W-2] == 2'b00));
endmodule

// File: rtl/rx_buffer_flags.sv
module rx_buffer_flags #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rd_strobe,
  input  logic              xfer,
  input  logic [DATA_W-1:0] shreg,
  input  logic              ovr_hit,
  input  logic              fe_hit,
  input  logic              pe_hit,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_sum
);
  logic [DATA_W-1:0] data_d;
  logic full_d, ovr_d, fe_d, pe_d, sum_d;

  always_comb begin
    data_d = xfer ? shreg : rx_data;
    if (xfer)           full_d = 1'b1;
    else if (rd_strobe) full_d = 1'b0;
    else                full_d = rx_full;
    if (!rx_en) begin
      ovr_d = 1'b0;
      fe_d  = 1'b0;
      pe_d  = 1'b0;
      sum_d = 1'b0;
    end else begin
      ovr_d = err_overrun | ovr_hit;
      fe_d  = err_frame   | fe_hit;
      pe_d  = err_parity  | pe_hit;
      sum_d = err_sum | ovr_hit | fe_hit | pe_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      rx_irq      <= 1'b0;
      err_overrun <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      err_sum     <= 1'b0;
    end else begin
      rx_data     <= data_d;
      rx_full     <= full_d;
      rx_irq      <= xfer;
      err_overrun <= ovr_d;
      err_frame   <= fe_d;
      err_parity  <= pe_d;
      err_sum     <= sum_d;
    end
  end

  // R5: an interrupt request always comes with a full buffer and lasts one cycle
  a_r5_irq_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  // R6: a read with no competing transfer empties the buffer
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !xfer) |=> !rx_full);
  // R10: the summary flag tracks the three individual flags
  a_r10_sum_any: assert property (@(posedge clk) disable iff (!rst_n)
    err_sum == (err_overrun || err_frame || err_parity));
  // R11: disabling reception wipes every flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !(err_sum || err_overrun || err_frame || err_parity));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DIV_W       = 8,
  parameter int OS_RATE     = 16,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2,
  localparam int OS_W       = $clog2(OS_RATE),
  localparam int IDX_W      = $clog2(DATA_W + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [DIV_W-1:0]  div_n,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              two_stop,
  input  logic              rxd,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_sum
);
  logic line, run, os_clr, tick, xfer, ovr_hit, fe_hit, pe_hit;
  logic [OS_W-1:0]   os;
  logic [DATA_W-1:0] shreg;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line)
  );

  rx_baud_gen #(.DIV_W(DIV_W), .OS_RATE(OS_RATE)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .os_clr(os_clr),
    .div_n(div_n), .tick(tick), .os(os)
  );

  rx_frame_ctrl #(.OS_RATE(OS_RATE), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .line(line), .tick(tick), .os(os),
    .char_len(char_len), .par_mode(par_mode), .two_stop(two_stop),
    .buf_full(rx_full), .run(run), .os_clr(os_clr), .shreg(shreg),
    .xfer(xfer), .ovr_hit(ovr_hit), .fe_hit(fe_hit), .pe_hit(pe_hit)
  );

  rx_buffer_flags #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe),
    .xfer(xfer), .shreg(shreg), .ovr_hit(ovr_hit), .fe_hit(fe_hit), .pe_hit(pe_hit),
    .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
    .err_overrun(err_overrun), .err_frame(err_frame),
    .err_parity(err_parity), .err_sum(err_sum)
  );
endmodule

// File: tb/serial_rx_core_test.sv
`timescale 1ns/1ps
module serial_rx_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic [7:0] div_n = 8'd0;
  logic [1:0] char_len = 2'd1;
  logic [1:0] par_mode = 2'd0;
  logic two_stop = 1'b0;
  logic rxd = 1'b1;
  logic rd_strobe = 1'b0;
  logic [8:0] rx_data;
  logic rx_full, rx_irq, err_overrun, err_frame, err_parity, err_sum;

  always #5 clk = ~clk;

  serial_rx_core uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .div_n(div_n), .char_len(char_len),
    .par_mode(par_mode), .two_stop(two_stop), .rxd(rxd), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
    .err_overrun(err_overrun), .err_frame(err_frame),
    .err_parity(err_parity), .err_sum(err_sum)
  );

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  int irq_count = 0;
  int last_irq_cyc = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s1, m_s2, m_busy, m_cnt, m_ovrf;
  logic [8:0] m_sh;
  logic [8:0] e_data;
  int e_full, e_irq, e_ovr, e_fe, e_pe, e_sum;

  always @(posedge clk) begin
    int line, tk, j, len, par, stops, total, ones;
    int xf;
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_busy = 0; m_cnt = 0; m_ovrf = 0; m_sh = '0;
      e_data = '0; e_full = 0; e_irq = 0; e_ovr = 0; e_fe = 0; e_pe = 0; e_sum = 0;
    end else begin
      line = m_s2; m_s2 = m_s1; m_s1 = int'(rxd);
      xf = 0;
      len = (char_len == 2'd0) ? 7 : (char_len == 2'd2) ? 9 : 8;
      par = (par_mode == 2'd1 || par_mode == 2'd2) ? 1 : 0;
      stops = two_stop ? 2 : 1;
      total = len + par + stops;
      if (!rx_en) begin
        m_busy = 0; e_ovr = 0; e_fe = 0; e_pe = 0; e_sum = 0;
      end else if (m_busy == 0) begin
        if (line == 0) begin
          m_busy = 1; m_cnt = 0; m_sh = '0; m_ovrf = 0;
        end
      end else begin
        m_cnt++;
        if (m_cnt % (int'(div_n) + 1) == 0) begin
          tk = m_cnt / (int'(div_n) + 1);
          if (tk == 8) begin
            if (line != 0) m_busy = 0;
          end else if (tk > 8 && (tk - 8) % 16 == 0) begin
            j = (tk - 8) / 16 - 1;
            if (j < len) m_sh[j] = (line != 0);
            else if (par == 1 && j == len) begin
              ones = $countones(m_sh) + line;
              if ((par_mode == 2'd1) ? (ones % 2 == 1) : (ones % 2 == 0)) begin
                e_pe = 1; e_sum = 1;
              end
            end else if (line == 0) begin
              e_fe = 1; e_sum = 1;
            end
            if (j == total - 2 && e_full == 1) begin
              e_ovr = 1; e_sum = 1; m_ovrf = 1;
            end
            if (j == total - 1) begin
              m_busy = 0;
              if (m_ovrf == 0) begin xf = 1; e_data = m_sh; end
            end
          end
        end
      end
      e_irq = xf;
      if (xf == 1) e_full = 1;
      else if (rd_strobe) e_full = 0;
    end
  end

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4", "rx_data", int'(rx_data), int'(e_data));
      chk("R6", "rx_full", int'(rx_full), e_full);
      chk("R5", "rx_irq", int'(rx_irq), e_irq);
      chk("R7", "err_overrun", int'(err_overrun), e_ovr);
      chk("R8", "err_frame", int'(err_frame), e_fe);
      chk("R9", "err_parity", int'(err_parity), e_pe);
      chk("R10", "err_sum", int'(err_sum), e_sum);
    end
    if (rx_irq) begin
      irq_count++;
      last_irq_cyc = cyc;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic host_read();
    rd_strobe = 1'b1;
    step(1);
    rd_strobe = 1'b0;
  endtask

  task automatic pulse_disable();
    rx_en = 1'b0;
    step(1);
    rx_en = 1'b1;
  endtask

  int frame_start;

  task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_stop);
    logic [15:0] bits;
    int nb, len, bitlen;
    logic p;
    len = (char_len == 2'd0) ? 7 : (char_len == 2'd2) ? 9 : 8;
    bits = '0;
    nb = 1;
    p = 1'b0;
    for (int k = 0; k < len; k++) begin
      bits[nb] = d[k];
      p = p ^ d[k];
      nb++;
    end
    if (par_mode == 2'd1 || par_mode == 2'd2) begin
      bits[nb] = ((par_mode == 2'd1) ? p : ~p) ^ bad_par;
      nb++;
    end
    bits[nb] = 1'b1;
    nb++;
    if (two_stop) begin
      bits[nb] = 1'b1;
      nb++;
    end
    if (bad_stop) bits[nb-1] = 1'b0;
    bitlen = 16 * (int'(div_n) + 1);
    frame_start = cyc;
    for (int k = 0; k < nb; k++) begin
      rxd = bits[k];
      step(bitlen);
    end
    rxd = 1'b1;
    step(2 * bitlen);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int base;
    step(3);
    // R1: reset state
    chk("R1", "rx_data at reset", int'(rx_data), 0);
    chk("R1", "flags at reset", int'({rx_full, rx_irq, err_overrun, err_frame, err_parity, err_sum}), 0);
    rst_n = 1'b1;
    step(2);
    chk("R1", "flags after release", int'({rx_full, rx_irq, err_sum}), 0);
    rx_en = 1'b1;
    step(4);

    // 8 data bits, no parity, one stop, n=0; exact transfer cycle (R2)
    div_n = 8'd0; char_len = 2'd1; par_mode = 2'd0; two_stop = 1'b0;
    send_frame(9'h0A5, 1'b0, 1'b0);
    chk("R2", "transfer cycle offset", last_irq_cyc - frame_start, 3 + (8 + 16 * 9) * 1);
    chk("R4", "8-bit character", int'(rx_data), 'hA5);
    chk("R5", "buffer full after transfer", int'(rx_full), 1);
    host_read();
    chk("R6", "full cleared by read", int'(rx_full), 0);

    // 7 bits, even parity, two stops, n=2
    div_n = 8'd2; char_len = 2'd0; par_mode = 2'd1; two_stop = 1'b1;
    send_frame(9'h1DA, 1'b0, 1'b0);
    chk("R2", "transfer cycle offset n=2", last_irq_cyc - frame_start, 3 + (8 + 16 * 10) * 3);
    chk("R4", "7-bit character upper bits zero", int'(rx_data), 'h5A);
    chk("R9", "no parity error on good even frame", int'(err_parity), 0);
    host_read();

    // 9 bits, odd parity, one stop, n=1
    div_n = 8'd1; char_len = 2'd2; par_mode = 2'd2; two_stop = 1'b0;
    send_frame(9'h1C3, 1'b0, 1'b0);
    chk("R4", "9-bit character", int'(rx_data), 'h1C3);
    chk("R9", "no parity error on good odd frame", int'(err_parity), 0);
    host_read();

    // parity error, 8 bits even
    div_n = 8'd0; char_len = 2'd1; par_mode = 2'd1;
    send_frame(9'h033, 1'b1, 1'b0);
    chk("R9", "parity error flagged", int'(err_parity), 1);
    chk("R10", "sum follows parity", int'(err_sum), 1);
    chk("R5", "character still delivered", int'(rx_data), 'h33);
    host_read();
    step(5);
    chk("R11", "flag sticky", int'(err_parity), 1);
    pulse_disable();
    chk("R11", "flags cleared by disable", int'({err_overrun, err_frame, err_parity, err_sum}), 0);

    // framing error on second stop bit
    par_mode = 2'd0; two_stop = 1'b1;
    send_frame(9'h0F0, 1'b0, 1'b1);
    chk("R8", "second stop low flags framing", int'(err_frame), 1);
    chk("R10", "sum follows framing", int'(err_sum), 1);
    host_read();
    pulse_disable();
    two_stop = 1'b0;

    // false start glitch
    base = irq_count;
    rxd = 1'b0;
    step(5);
    rxd = 1'b1;
    step(40);
    chk("R3", "glitch gives no transfer", irq_count - base, 0);
    chk("R3", "glitch gives no full", int'(rx_full), 0);
    send_frame(9'h081, 1'b0, 1'b0);
    chk("R3", "frame after glitch", int'(rx_data), 'h81);
    host_read();

    // overrun: two frames without a read
    base = irq_count;
    send_frame(9'h03C, 1'b0, 1'b0);
    send_frame(9'h0C3, 1'b0, 1'b0);
    chk("R7", "overrun flagged", int'(err_overrun), 1);
    chk("R7", "old character kept", int'(rx_data), 'h3C);
    chk("R7", "single interrupt", irq_count - base, 1);
    chk("R10", "sum follows overrun", int'(err_sum), 1);
    host_read();
    pulse_disable();

    // disabled receiver ignores the line
    base = irq_count;
    rx_en = 1'b0;
    send_frame(9'h055, 1'b0, 1'b0);
    chk("R12", "no transfer while disabled", irq_count - base, 0);
    chk("R12", "buffer untouched while disabled", int'(rx_data), 'h3C);
    chk("R12", "full stays clear", int'(rx_full), 0);
    rx_en = 1'b1;
    step(4);
    send_frame(9'h0AA, 1'b0, 1'b0);
    chk("R12", "reception resumes", int'(rx_data), 'hAA);

    step(4);
    finish_run();
  end
endmodule